// File: doc/BRIEF.md
# Two-Word Instruction Decoder

This decode stage takes a 16-bit instruction stream, one word per accepted cycle. Most words finish in one word. A small group of opcodes needs a second word. The stage holds the first word of such a pair, waits for its continuation word, and then issues a single combined micro-operation. That micro-operation carries an operation class and two 12-bit operands. A continuation word always has an all-ones top nibble. When a conditional skip jumps over the first word, the continuation word that follows arrives alone, and the stage reports it as a no-operation.

The sequencer presents each fetched word with `in_valid`. It raises `in_skip` when a preceding conditional test has decided that this word must not execute. Results appear on registered outputs one clock after the word is accepted. The ALU, the register file, the program counter and memory timing belong to other blocks.

Top module: `twd_decoder`

## Requirements
- R1: While reset is held, every output is 0. After reset the pair-pending state is clear, so the first word after reset is decoded as a fresh word (a lone 0xF word gives a no-op, and a first word followed by its continuation gives a combined result).
- R2: A word with top nibble 1100 is the first word of a file-to-file move. It produces no result and sets pending. The next accepted word with top nibble 1111 produces `out_valid` with class 1, `out_opa` = first word bits [11:0] and `out_opb` = continuation bits [11:0]. Example: 0xC123 then 0xF456 gives class 1, 0x123, 0x456.
- R3: A word with top nibble 1110 is selected by bits [11:10]. 00 is goto (class 2), 01 is call (class 3) and 10 is file-select load (class 4). Each of these is a first word with `out_opa` = {00, bits [9:0]}. The value 11 is a single-word instruction.
- R4: A top-nibble-1111 word accepted while nothing is pending gives `out_nop` = 1 for one cycle, with `out_valid` = 0.
- R5: A word accepted with `in_skip` = 1 while nothing is pending is discarded. It gives no output and leaves pending clear, so a continuation word after a skipped first word gives `out_nop`.
- R6: While pending, `in_skip` is ignored, and the continuation word still completes the pair.
- R7: While pending, a word whose top nibble is not 1111 gives `out_err` = 1 for one cycle and clears pending. The word itself is dropped.
- R8: Any other executed word gives `out_valid` with class 0, `out_opa` = bits [11:0] and `out_opb` = 0.
- R9: At most one of `out_valid`, `out_nop` and `out_err` is high in a cycle. Each high level lasts one cycle, and `out_class`, `out_opa` and `out_opb` read 0 whenever `out_valid` is 0.
- R10: A cycle with `in_valid` = 0 gives no output and leaves pending unchanged, so a pair may be split by idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A fetched word is presented this cycle |
| in_skip | input | 1 | The presented word was skipped by a conditional test |
| in_word | input | 16 | Fetched instruction word |
| out_valid | output | 1 | Completed micro-operation strobe |
| out_class | output | 3 | Operation class: 0 single, 1 move, 2 goto, 3 call, 4 file-select load |
| out_opa | output | 12 | First operand |
| out_opb | output | 12 | Second operand |
| out_nop | output | 1 | Orphan continuation word executed as no-op |
| out_err | output | 1 | Non-continuation word followed a first word |

## Verification
The only hidden state is the pending flag with the latched class and operand. A wrong pending flag becomes visible on the very next accepted word. A lost flag turns a completing continuation word into an `out_nop`, and a stuck flag turns the next ordinary word into an `out_err`. A corrupted latched class or operand shows on the combined result one cycle after the continuation word. The vectors therefore put each first word directly against a continuation, an orphan, a skip and an illegal follower.

// File: rtl/twd_pkg.sv
package twd_pkg;
  typedef enum logic [2:0] {
    CLS_SINGLE = 3'd0,
    CLS_MOVE   = 3'd1,
    CLS_GOTO   = 3'd2,
    CLS_CALL   = 3'd3,
    CLS_FSRLD  = 3'd4
  } op_class_e;

  typedef enum logic [1:0] {
    KIND_SINGLE = 2'd0,
    KIND_HEAD   = 2'd1,
    KIND_TAIL   = 2'd2
  } word_kind_e;
endpackage

// File: rtl/twd_classify.sv
module twd_classify
  import twd_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAY_W  = 12,
  parameter int unsigned SUB_W  = 2
) (
  input  logic [WORD_W-1:0] word,
  output word_kind_e        kind,
  output op_class_e         head_cls,
  output logic [PAY_W-1:0]  head_opa
);
  localparam int unsigned NIB_W = WORD_W - PAY_W;
  localparam int unsigned LOW_W = PAY_W - SUB_W;
  localparam logic [NIB_W-1:0] NIB_TAIL   = {NIB_W{1'b1}};
  localparam logic [NIB_W-1:0] NIB_MOVE   = NIB_TAIL - NIB_W'(3);
  localparam logic [NIB_W-1:0] NIB_BRANCH = NIB_TAIL - NIB_W'(1);

  logic [NIB_W-1:0] nib;
  logic [SUB_W-1:0] sub;

  assign nib = word[WORD_W-1 -: NIB_W];
  assign sub = word[PAY_W-1 -: SUB_W];

  always_comb begin
    kind     = KIND_SINGLE;
    head_cls = CLS_SINGLE;
    head_opa = word[PAY_W-1:0];
    if (nib == NIB_TAIL) begin
      kind = KIND_TAIL;
    end else if (nib == NIB_MOVE) begin
      kind     = KIND_HEAD;
      head_cls = CLS_MOVE;
    end else if (nib == NIB_BRANCH) begin
      case (sub)
        SUB_W'(0): begin kind = KIND_HEAD; head_cls = CLS_GOTO;  end
        SUB_W'(1): begin kind = KIND_HEAD; head_cls = CLS_CALL;  end
        SUB_W'(2): begin kind = KIND_HEAD; head_cls = CLS_FSRLD; end
        default:   begin kind = KIND_SINGLE; head_cls = CLS_SINGLE; end
      endcase
      if (kind == KIND_HEAD) begin
        head_opa = {{SUB_W{1'b0}}, word[LOW_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/twd_pending.sv
module twd_pending
  import twd_pkg::*;
#(
  parameter int unsigned PAY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             arm,
  input  op_class_e        cls_in,
  input  logic [PAY_W-1:0] opa_in,
  output logic             pend_q,
  output op_class_e        cls_q,
  output logic [PAY_W-1:0] opa_q
);
  logic             pend_d;
  op_class_e        cls_d;
  logic [PAY_W-1:0] opa_d;

  always_comb begin
    pend_d = pend_q;
    cls_d  = cls_q;
    opa_d  = opa_q;
    if (en) begin
      pend_d = arm;
      if (arm) begin
        cls_d = cls_in;
        opa_d = opa_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cls_q  <= CLS_SINGLE;
      opa_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cls_q  <= cls_d;
      opa_q  <= opa_d;
    end
  end
endmodule

// File: rtl/twd_emit.sv
module twd_emit
  import twd_pkg::*;
#(
  parameter int unsigned PAY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_pair,
  input  logic             fire_single,
  input  logic             fire_nop,
  input  logic             fire_err,
  input  op_class_e        pair_cls,
  input  logic [PAY_W-1:0] pair_opa,
  input  logic [PAY_W-1:0] cur_pay,
  output logic             valid_q,
  output op_class_e        cls_q,
  output logic [PAY_W-1:0] opa_q,
  output logic [PAY_W-1:0] opb_q,
  output logic             nop_q,
  output logic             err_q
);
  logic             valid_d;
  op_class_e        cls_d;
  logic [PAY_W-1:0] opa_d;
  logic [PAY_W-1:0] opb_d;

  always_comb begin
    valid_d = fire_pair | fire_single;
    cls_d   = CLS_SINGLE;
    opa_d   = '0;
    opb_d   = '0;
    if (fire_pair) begin
      cls_d = pair_cls;
      opa_d = pair_opa;
      opb_d = cur_pay;
    end else if (fire_single) begin
      opa_d = cur_pay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cls_q   <= CLS_SINGLE;
      opa_q   <= '0;
      opb_q   <= '0;
      nop_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      cls_q   <= cls_d;
      opa_q   <= opa_d;
      opb_q   <= opb_d;
      nop_q   <= fire_nop;
      err_q   <= fire_err;
    end
  end
endmodule

// File: rtl/twd_decoder.sv
module twd_decoder
  import twd_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAY_W  = 12,
  parameter int unsigned SUB_W  = 2,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_skip,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [2:0]        out_class,
  output logic [PAY_W-1:0]  out_opa,
  output logic [PAY_W-1:0]  out_opb,
  output logic              out_nop,
  output logic              out_err
);
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_N-1];

  word_kind_e       kind;
  op_class_e        head_cls;
  logic [PAY_W-1:0] head_opa;

  twd_classify #(.WORD_W(WORD_W), .PAY_W(PAY_W), .SUB_W(SUB_W)) i_classify (
    .word     (in_word),
    .kind     (kind),
    .head_cls (head_cls),
    .head_opa (head_opa)
  );

  logic             pend_q;
  op_class_e        pend_cls;
  logic [PAY_W-1:0] pend_opa;
  logic             exec, arm, fire_pair, fire_single, fire_nop, fire_err;

  always_comb begin
    exec        = in_valid & (pend_q | ~in_skip);
    arm         = exec & ~pend_q & (kind == KIND_HEAD);
    fire_pair   = exec &  pend_q & (kind == KIND_TAIL);
    fire_err    = exec &  pend_q & (kind != KIND_TAIL);
    fire_nop    = exec & ~pend_q & (kind == KIND_TAIL);
    fire_single = exec & ~pend_q & (kind == KIND_SINGLE);
  end

  twd_pending #(.PAY_W(PAY_W)) i_pending (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (exec),
    .arm    (arm),
    .cls_in (head_cls),
    .opa_in (head_opa),
    .pend_q (pend_q),
    .cls_q  (pend_cls),
    .opa_q  (pend_opa)
  );

  op_class_e out_cls_e;

  twd_emit #(.PAY_W(PAY_W)) i_emit (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .fire_pair   (fire_pair),
    .fire_single (fire_single),
    .fire_nop    (fire_nop),
    .fire_err    (fire_err),
    .pair_cls    (pend_cls),
    .pair_opa    (pend_opa),
    .cur_pay     (in_word[PAY_W-1:0]),
    .valid_q     (out_valid),
    .cls_q       (out_cls_e),
    .opa_q       (out_opa),
    .opb_q       (out_opb),
    .nop_q       (out_nop),
    .err_q       (out_err)
  );

  assign out_class = out_cls_e;
endmodule

// File: rtl/twd_decoder_chk.sv
module twd_decoder_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAY_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_skip,
  input logic [WORD_W-1:0] in_word,
  input logic              pend,
  input logic              out_valid,
  input logic [PAY_W-1:0]  out_opb,
  input logic              out_nop,
  input logic              out_err
);
  localparam int unsigned NIB_W = WORD_W - PAY_W;
  localparam logic [NIB_W-1:0] NIB_TAIL = {NIB_W{1'b1}};
  localparam logic [NIB_W-1:0] NIB_MOVE = NIB_TAIL - NIB_W'(3);

  logic [NIB_W-1:0] nib;
  assign nib = in_word[WORD_W-1 -: NIB_W];

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, out_nop, out_err})); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_nop && !out_err)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pend)); // R10
  AST_HEAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_skip && !pend && nib == NIB_MOVE) |=> (pend && !out_valid)); // R2
  AST_TAIL_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pend && nib == NIB_TAIL) |=> (out_valid && !pend && out_opb == $past(in_word[PAY_W-1:0]))); // R6
  AST_ORPHAN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_skip && !pend && nib == NIB_TAIL) |=> (out_nop && !out_valid)); // R4
  AST_SKIP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_skip && !pend) |=> (!out_valid && !out_nop && !out_err && !pend)); // R5
  AST_BAD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pend && nib != NIB_TAIL) |=> (out_err && !pend)); // R7
endmodule

bind twd_decoder twd_decoder_chk #(.WORD_W(WORD_W), .PAY_W(PAY_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_skip   (in_skip),
  .in_word   (in_word),
  .pend      (pend_q),
  .out_valid (out_valid),
  .out_opb   (out_opb),
  .out_nop   (out_nop),
  .out_err   (out_err)
);

// File: tb/test_twd_decoder.sv
module test_twd_decoder;
  typedef struct packed {
    logic [23:0] tag;
    logic        vld;
    logic        skp;
    logic [15:0] word;
    logic        ev;
    logic [2:0]  ecls;
    logic [11:0] ea;
    logic [11:0] eb;
    logic        en;
    logic        ee;
  } vec_t;

  function automatic vec_t mk(input logic [23:0] tag, input logic vld, input logic skp,
                              input logic [15:0] word, input logic ev, input logic [2:0] ecls,
                              input logic [11:0] ea, input logic [11:0] eb,
                              input logic en, input logic ee);
    mk = '{tag, vld, skp, word, ev, ecls, ea, eb, en, ee};
  endfunction

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    mk("R2 ", 1, 0, 16'hC123, 0, 3'd0, 12'h000, 12'h000, 0, 0),
    mk("R2 ", 1, 0, 16'hF456, 1, 3'd1, 12'h123, 12'h456, 0, 0),
    mk("R3 ", 1, 0, 16'hE005, 0, 3'd0, 12'h000, 12'h000, 0, 0),
    mk("R10", 0, 0, 16'h1234, 0, 3'd0, 12'h000, 12'h000, 0, 0),
    mk("R3 ", 1, 0, 16'hF789, 1, 3'd2, 12'h005, 12'h789, 0, 0),
    mk("R3 ", 1, 0, 16'hE5AB, 0, 3'd0, 12'h000, 12'h000, 0, 0),
    mk("R3 ", 1, 0, 16'hF001, 1, 3'd3, 12'h1AB, 12'h001, 0, 0),
    mk("R3 ", 1, 0, 16'hEBFF, 0, 3'd0, 12'h000, 12'h000, 0, 0),
    mk("R6 ", 1, 1, 16'hFABC, 1, 3'd4, 12'h3FF, 12'hABC, 0, 0),
    mk("R4 ", 1, 0, 16'hFDEF, 0, 3'd0, 12'h000, 12'h000, 1, 0),
    mk("R9 ", 0, 0, 16'h0000, 0, 3'd0, 12'h000, 12'h000, 0, 0),
    mk("R5 ", 1, 1, 16'hC222, 0, 3'd0, 12'h000, 12'h000, 0, 0),
    mk("R5 ", 1, 0, 16'hF333, 0, 3'd0, 12'h000, 12'h000, 1, 0),
    mk("R3 ", 1, 0, 16'hECDE, 1, 3'd0, 12'hCDE, 12'h000, 0, 0),
    mk("R8 ", 1, 0, 16'h1234, 1, 3'd0, 12'h234, 12'h000, 0, 0),
    mk("R7 ", 1, 0, 16'hC010, 0, 3'd0, 12'h000, 12'h000, 0, 0),
    mk("R7 ", 1, 0, 16'h2000, 0, 3'd0, 12'h000, 12'h000, 0, 1),
    mk("R7 ", 1, 0, 16'hF020, 0, 3'd0, 12'h000, 12'h000, 1, 0),
    mk("R5 ", 1, 1, 16'h5555, 0, 3'd0, 12'h000, 12'h000, 0, 0)
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_skip;
  logic [15:0] in_word;
  logic        out_valid;
  logic [2:0]  out_class;
  logic [11:0] out_opa;
  logic [11:0] out_opb;
  logic        out_nop;
  logic        out_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  twd_decoder i_twd_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_skip   (in_skip),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_class (out_class),
    .out_opa   (out_opa),
    .out_opb   (out_opb),
    .out_nop   (out_nop),
    .out_err   (out_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic [23:0] tag, input logic ev, input logic [2:0] ecls,
                       input logic [11:0] ea, input logic [11:0] eb,
                       input logic en, input logic ee);
    logic [29:0] act, exp;
    act = {out_valid, out_class, out_opa, out_opb, out_nop, out_err};
    exp = {ev, ecls, ea, eb, en, ee};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got v=%b c=%0d a=%h b=%h n=%b e=%b, expected v=%b c=%0d a=%h b=%h n=%b e=%b",
               tag, out_valid, out_class, out_opa, out_opb, out_nop, out_err,
               ev, ecls, ea, eb, en, ee);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic [15:0] w);
    in_valid = v;
    in_skip  = s;
    in_word  = w;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got running, expected finished");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_skip  = 1'b0;
    in_word  = '0;
    repeat (3) @(negedge clk);
    check("R1 ", 0, 3'd0, 12'h000, 12'h000, 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: first word after reset decodes as a fresh pair
    drive(1, 0, 16'hC0AA);
    check("R1 ", 0, 3'd0, 12'h000, 12'h000, 0, 0);
    drive(1, 0, 16'hF0BB);
    check("R1 ", 1, 3'd1, 12'h0AA, 12'h0BB, 0, 0);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].vld, VECS[i].skp, VECS[i].word);
      check(VECS[i].tag, VECS[i].ev, VECS[i].ecls, VECS[i].ea, VECS[i].eb,
            VECS[i].en, VECS[i].ee);
    end

    // R1: reset during a pending pair clears it
    drive(1, 0, 16'hC111);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    check("R1 ", 0, 3'd0, 12'h000, 12'h000, 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(1, 0, 16'hF222);
    check("R1 ", 0, 3'd0, 12'h000, 12'h000, 1, 0);

    // R10: long idle gap inside a pair
    drive(1, 0, 16'hE3FF);
    drive(0, 0, 16'hF000);
    drive(0, 1, 16'h0000);
    check("R10", 0, 3'd0, 12'h000, 12'h000, 0, 0);
    drive(1, 0, 16'hFFFF);
    check("R10", 1, 3'd2, 12'h3FF, 12'hFFF, 0, 0);

    // R9: pulse lasts a single cycle
    drive(0, 0, 16'h0000);
    check("R9 ", 0, 3'd0, 12'h000, 12'h000, 0, 0);

    finish_run();
  end
endmodule